// File: doc/BRIEF.md
# Redundant Reference Clock Switch Monitor

This block watches two reference clocks from a free-running monitor clock and decides which of them should feed a downstream clock path. Each reference passes through a synchronizer into the monitor domain. A watch counter declares a reference lost when no rising edge has arrived for a set number of monitor cycles. An active-low failure flag for each reference latches that loss. An indicator output names the reference that is in use.

In automatic mode the block fails over from a lost active reference to a healthy standby, whatever the primary-select input says. After a failover the selection stays where it is until an alarm clear. In manual mode, or when the bypass input is high, the indicator simply follows the primary-select input, and the failure flags keep being monitored. The alarm clear acts on its rising edge only. That edge raises both flags and points the indicator back at the primary, and monitoring carries on while the input stays high.

Top module: `refclk_guard`

## Requirements
- R1: An asynchronous active-low reset sets both failure flags high and sets the indicator to the primary-select value held during reset. Indicator 0 means reference 0 and 1 means reference 1.
- R2: With manual_mode = 1, the indicator equals the primary-select value of the previous monitor cycle. A lost reference does not switch the selection.
- R3: In automatic mode (manual_mode = 0, bypass = 0), when the active reference is lost and the other reference is neither lost nor flagged, the indicator moves to the other reference. In automatic mode, changes of the primary-select input alone do not move the indicator.
- R4: A reference is declared lost when TIMEOUT (default 8) monitor cycles pass with no synchronized rising edge on it. Its flag then goes low one cycle later. A reference with a rising edge every 4 monitor cycles is never flagged, and a flag does not fall within 6 cycles of the last edge.
- R5: A low failure flag stays low until an alarm-clear edge, even if the reference recovers. After a failover the indicator does not return to the primary on its own.
- R6: On a rising edge of alarm_clr, both flags are high and the indicator equals primary-select in the next cycle.
- R7: The alarm clear is one-shot. While alarm_clr stays high after its edge, a newly lost reference still drives its flag low.
- R8: When both references are flagged in automatic mode, the indicator holds its value and does not alternate.
- R9: With bypass = 1, the block behaves as in manual mode. The indicator follows primary-select, and a lost active reference lowers its flag without a switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock |
| mon_rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk0 | input | 1 | Reference clock 0, sampled as data |
| ref_clk1 | input | 1 | Reference clock 1, sampled as data |
| pri_sel | input | 1 | Primary reference select (0 = ref 0, 1 = ref 1) |
| manual_mode | input | 1 | 1 = manual selection, 0 = automatic failover |
| bypass | input | 1 | 1 = failover disabled, behaves as manual |
| alarm_clr | input | 1 | One-shot alarm clear, acts on rising edge |
| fail0_n | output | 1 | Reference 0 failure flag, low = failed |
| fail1_n | output | 1 | Reference 1 failure flag, low = failed |
| sel_ind | output | 1 | Reference in use (0 = ref 0, 1 = ref 1) |

## Verification
A wrong watch counter shows up as a flag falling while its reference still toggles, or as no fall within about a dozen monitor cycles of the reference stopping. Both are visible on fail0_n or fail1_n within two timeout windows. A wrong selection state shows on sel_ind one cycle after the triggering event: a failover that does not happen, a switch back without a clear, or a flip between two dead references. A wrong clear detector shows either as flags that stay low after a clear edge, or as a failure that is masked while alarm_clr is held high.

// File: rtl/refclk_guard_pkg.sv
package refclk_guard_pkg;
  localparam int unsigned NUM_REFS = 2;

  // index of the standby reference for a given active one
  function automatic logic other_ref(input logic idx);
    return ~idx;
  endfunction

  // true once the quiet count has reached the allowed window
  function automatic logic window_expired(input int unsigned count, input int unsigned limit);
    return count >= limit;
  endfunction
endpackage

// File: rtl/refclk_edge_watch.sv
module refclk_edge_watch
  import refclk_guard_pkg::*;
#(
  parameter int unsigned TIMEOUT     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic lost
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);

  // synchronizer stages plus one history stage for edge detection
  logic [SYNC_STAGES:0] shift_q;
  logic [CW-1:0]        quiet_q;
  logic                 edge_seen;

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[SYNC_STAGES-1:0], ref_in};
  end

  assign edge_seen = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
  assign lost      = window_expired(32'(quiet_q), TIMEOUT);

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n)         quiet_q <= '0;
    else if (edge_seen) quiet_q <= '0;
    else if (!lost)     quiet_q <= quiet_q + CW'(1);
  end

  // R4: a fresh edge always clears the loss indication
  a_r4_edge_clears_loss: assert property (@(posedge mon_clk) disable iff (!rst_n)
    edge_seen |=> !lost);
  // R4: loss persists while the reference stays quiet
  a_r4_loss_sticks: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (lost && !edge_seen) |=> lost);
endmodule

// File: rtl/refclk_sel_fsm.sv
module refclk_sel_fsm
  import refclk_guard_pkg::*;
(
  input  logic                mon_clk,
  input  logic                rst_n,
  input  logic                pri_sel,
  input  logic                manual_mode,
  input  logic                bypass,
  input  logic                alarm_clr,
  input  logic [NUM_REFS-1:0] lost,
  output logic [NUM_REFS-1:0] fail_n,
  output logic                sel_ind
);
  logic clr_q;
  logic clr_evt;
  logic auto_on;
  logic stby;
  logic switch_evt;

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= alarm_clr;
  end

  assign clr_evt    = alarm_clr & ~clr_q;
  assign auto_on    = ~manual_mode & ~bypass;
  assign stby       = other_ref(sel_ind);
  assign switch_evt = auto_on & lost[sel_ind] & ~lost[stby] & fail_n[stby];

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_flag
    always_ff @(posedge mon_clk or negedge rst_n) begin
      if (!rst_n)       fail_n[i] <= 1'b1;
      else if (clr_evt) fail_n[i] <= 1'b1;
      else if (lost[i]) fail_n[i] <= 1'b0;
    end

    // R4: a lost reference lowers its flag on the next edge
    a_r4_flag_on_loss: assert property (@(posedge mon_clk) disable iff (!rst_n)
      (lost[i] && !clr_evt) |=> !fail_n[i]);
    // R5: flags stay low until a clear edge
    a_r5_flag_latched: assert property (@(posedge mon_clk) disable iff (!rst_n)
      (!fail_n[i] && !clr_evt) |=> !fail_n[i]);
  end

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n)          sel_ind <= pri_sel;
    else if (clr_evt)    sel_ind <= pri_sel;
    else if (!auto_on)   sel_ind <= pri_sel;
    else if (switch_evt) sel_ind <= stby;
  end

  // R6: clear edge restores flags and primary selection
  a_r6_clear_restores: assert property (@(posedge mon_clk) disable iff (!rst_n)
    clr_evt |=> (fail_n == '1) && (sel_ind == $past(pri_sel)));
  // R2 / R9: manual or bypass tracks the select input
  a_r2_manual_tracks: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (manual_mode || bypass) |=> sel_ind == $past(pri_sel));
  // R3: automatic mode only moves on failover or clear
  a_r3_auto_holds: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (auto_on && !clr_evt && !lost[sel_ind]) |=> $stable(sel_ind));
  // R8: two failed references never cause a flip
  a_r8_both_hold: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (auto_on && !clr_evt && fail_n == '0) |=> $stable(sel_ind));
endmodule

// File: rtl/refclk_guard.sv
module refclk_guard
  import refclk_guard_pkg::*;
#(
  parameter int unsigned TIMEOUT     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic mon_rst_n,
  input  logic ref_clk0,
  input  logic ref_clk1,
  input  logic pri_sel,
  input  logic manual_mode,
  input  logic bypass,
  input  logic alarm_clr,
  output logic fail0_n,
  output logic fail1_n,
  output logic sel_ind
);
  logic [NUM_REFS-1:0] ref_vec;
  logic [NUM_REFS-1:0] lost;
  logic [NUM_REFS-1:0] fail_n;

  assign ref_vec = {ref_clk1, ref_clk0};

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_watch
    refclk_edge_watch #(.TIMEOUT(TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) u_watch (
      .mon_clk (mon_clk),
      .rst_n   (mon_rst_n),
      .ref_in  (ref_vec[i]),
      .lost    (lost[i])
    );
  end

  refclk_sel_fsm u_fsm (
    .mon_clk     (mon_clk),
    .rst_n       (mon_rst_n),
    .pri_sel     (pri_sel),
    .manual_mode (manual_mode),
    .bypass      (bypass),
    .alarm_clr   (alarm_clr),
    .lost        (lost),
    .fail_n      (fail_n),
    .sel_ind     (sel_ind)
  );

  assign fail0_n = fail_n[0];
  assign fail1_n = fail_n[1];
endmodule

// File: tb/refclk_guard_test.sv
module refclk_guard_test;
  logic mon_clk = 1'b0;
  logic mon_rst_n = 1'b0;
  logic ref_clk0 = 1'b0, ref_clk1 = 1'b0;
  logic pri_sel = 1'b1, manual_mode = 1'b0, bypass = 1'b0, alarm_clr = 1'b0;
  logic fail0_n, fail1_n, sel_ind;
  logic run0 = 1'b1, run1 = 1'b1;
  logic [1:0] div0 = '0, div1 = '0;
  int checks = 0, failures = 0, cycles = 0;

  refclk_guard uut (
    .mon_clk(mon_clk), .mon_rst_n(mon_rst_n), .ref_clk0(ref_clk0), .ref_clk1(ref_clk1),
    .pri_sel(pri_sel), .manual_mode(manual_mode), .bypass(bypass), .alarm_clr(alarm_clr),
    .fail0_n(fail0_n), .fail1_n(fail1_n), .sel_ind(sel_ind)
  );

  always #10 mon_clk = ~mon_clk;  // 50 MHz

  // reference generators: rising edge every 4 monitor cycles while running
  always @(negedge mon_clk) begin
    if (run0) begin
      if (div0 == 2'd1) begin ref_clk0 <= ~ref_clk0; div0 <= '0; end
      else div0 <= div0 + 2'd1;
    end
    if (run1) begin
      if (div1 == 2'd1) begin ref_clk1 <= ~ref_clk1; div1 <= '0; end
      else div1 <= div1 + 2'd1;
    end
  end

  always @(posedge mon_clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: {fail1_n,fail0_n,sel_ind} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge mon_clk);
  endtask

  function automatic logic [2:0] outs();
    return {fail1_n, fail0_n, sel_ind};
  endfunction

  task automatic pulse_clear();
    alarm_clr = 1'b1;
    wait_cyc(1);
    alarm_clr = 1'b0;
  endtask

  task automatic restore(input logic p);
    run0 = 1'b1; run1 = 1'b1; pri_sel = p;
    manual_mode = 1'b0; bypass = 1'b0;
    wait_cyc(6);
    pulse_clear();
    wait_cyc(4);
    chk("R6 restore", outs(), {2'b11, p});
  endtask

  task automatic t_reset();
    pri_sel = 1'b1;
    wait_cyc(3);
    chk("R1 during reset", outs(), 3'b111);
    mon_rst_n = 1'b1;
    wait_cyc(1);
    chk("R1 after reset", outs(), 3'b111);
  endtask

  task automatic t_healthy();
    wait_cyc(60);
    chk("R4 healthy refs never flagged", outs(), 3'b111);
  endtask

  task automatic t_auto_ignore();
    pri_sel = 1'b0;
    wait_cyc(5);
    chk("R3 auto ignores select", outs(), 3'b111);
  endtask

  task automatic t_failover();
    run1 = 1'b0;
    wait_cyc(6);
    chk("R4 no early flag", outs(), 3'b111);
    wait_cyc(20);
    chk("R3 failover to ref0", outs(), 3'b010);
  endtask

  task automatic t_latched();
    run1 = 1'b1;
    wait_cyc(40);
    chk("R5 flag latched and no return", outs(), 3'b010);
  endtask

  task automatic t_clear();
    pri_sel = 1'b1;
    alarm_clr = 1'b1;
    wait_cyc(1);
    chk("R6 clear edge", outs(), 3'b111);
    alarm_clr = 1'b0;
    wait_cyc(20);
    chk("R6 stays clear", outs(), 3'b111);
  endtask

  task automatic t_oneshot();
    alarm_clr = 1'b1;
    wait_cyc(3);
    run0 = 1'b0;
    wait_cyc(25);
    chk("R7 held clear does not mask loss", outs(), 3'b101);
    alarm_clr = 1'b0;
    restore(1'b1);
  endtask

  task automatic t_both();
    logic [2:0] snap;
    run0 = 1'b0; run1 = 1'b0;
    wait_cyc(30);
    snap = outs();
    chk("R8 both flagged", {snap[2:1], 1'b0}, 3'b000);
    wait_cyc(20);
    chk("R8 indicator holds", outs(), snap);
    restore(1'b0);
  endtask

  task automatic t_manual();
    manual_mode = 1'b1;
    pri_sel = 1'b1;
    wait_cyc(1);
    chk("R2 manual follows select 1", outs(), 3'b111);
    pri_sel = 1'b0;
    wait_cyc(1);
    chk("R2 manual follows select 0", outs(), 3'b110);
    run0 = 1'b0;
    wait_cyc(30);
    chk("R2 manual no switch, flag falls", outs(), 3'b100);
    restore(1'b1);
  endtask

  task automatic t_bypass();
    bypass = 1'b1;
    pri_sel = 1'b0;
    wait_cyc(1);
    chk("R9 bypass follows select", outs(), 3'b110);
    run0 = 1'b0;
    wait_cyc(30);
    chk("R9 bypass no switch, flag falls", outs(), 3'b100);
    restore(1'b0);
  endtask

  initial begin
    t_reset();
    t_healthy();
    t_auto_ignore();
    t_failover();
    t_latched();
    t_clear();
    t_oneshot();
    t_both();
    t_manual();
    t_bypass();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule